// File: doc/BRIEF.md
# TFT Panel Strobe Timing Generator

This block drives the five control strobes that a small portrait TFT panel needs in order to latch lines and frames. The visible area is 240 pixels by 320 lines, and nine lines that are never displayed are added to each frame. Every strobe has its own wrap-around counter. All of them advance on a single pixel-clock enable, `pix_ce`. The block has five outputs:
- a one-tick line latch pulse;
- a one-tick horizontal start pulse;
- a vertical start strobe that is two lines wide and repeats once per frame;
- an active-low pixel window at the front of each line;
- a polarity signal that alternates every line.

The counters must hold a fixed phase relationship, so they are started in three steps:
1. A `start_i` pulse starts the polarity counter.
2. The line-latch counter joins once the polarity count has passed `REV_GATE`.
3. The horizontal-start, vertical-start and pixel-window counters join together once the line-latch count reaches `LP_GATE`.

`stop_i` halts everything, and the next `start_i` replays the same three steps. All pins are plain control and status pins. There is no data stream, so no valid/ready handshake is needed.

The line length `LINE_CLKS` is a parameter. Its default is 303 ticks, which matches a 6 MHz pixel clock at 60 frames per second over 329 lines. The frame length is `LINE_CLKS * (ACT_LINES + BLANK_LINES)` ticks.

Top module: `tft_timing_gen`

## Requirements
- R1: After reset, and whenever the block is not running, `line_latch_o`, `hstart_o`, `vstart_o` and `polarity_o` are 0, `pix_win_n_o` is 1 and `running_o` is 0.
- R2: The polarity counter is enabled at the edge that samples `start_i`. Counting the `pix_ce` ticks after that edge as k = 0, 1, 2, ..., `polarity_o` is 1 while (k mod 2·LINE_CLKS) < LINE_CLKS and 0 otherwise.
- R3: `line_latch_o` is a one-tick pulse at k = REV_GATE+2 and every LINE_CLKS ticks after that. Its counter is enabled at the first `pix_ce` edge where the polarity count exceeds REV_GATE.
- R4: The horizontal-start, vertical-start and pixel-window counters start together at the first `pix_ce` edge where the line-latch count is at least LP_GATE, that is at k = G = REV_GATE+LP_GATE+3. `hstart_o` is a one-tick pulse at k = G and every LINE_CLKS ticks after that.
- R5: `vstart_o` is 1 while ((k−G) mod FRAME_CLKS) < 2·LINE_CLKS, where FRAME_CLKS = LINE_CLKS·(ACT_LINES+BLANK_LINES).
- R6: `pix_win_n_o` is active low. It is 0 while ((k−G) mod LINE_CLKS) < ACT_PIX+START_LN and 1 otherwise, including before the group has started.
- R7: While `pix_ce` is 0, no counter advances and every output holds its value.
- R8: A `start_i` pulse while `running_o` is 1 has no effect on any output phase.
- R9: `stop_i` is synchronous. At the next edge all counters clear, all outputs take their R1 idle levels and `running_o` falls. It overrides a simultaneous `start_i`, and a later `start_i` replays the R2–R6 sequence from k = 0.
- R10: `running_o` rises at the edge that samples `start_i` and stays 1 until a stop.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_ce | input | 1 | Pixel-clock enable; counters advance only on edges where it is 1 |
| start_i | input | 1 | Begins the staggered bring-up when idle |
| stop_i | input | 1 | Synchronous halt of all counters |
| running_o | output | 1 | High from start until stop |
| line_latch_o | output | 1 | One-tick line latch pulse |
| hstart_o | output | 1 | One-tick horizontal start pulse |
| vstart_o | output | 1 | Frame strobe, two lines wide |
| pix_win_n_o | output | 1 | Active-low pixel window per line |
| polarity_o | output | 1 | Line-alternating polarity signal |

## Verification
The bench runs the block with a reduced line length of 24 ticks and a six-line frame. It compares all five strobes against a closed-form model of k, both at a table of hand-picked tick positions and in every cycle of long sweeps.

The table positions are chosen to separate specific faults:
- the two gate thresholds (k = 12, 13, 16, 17), which expose an off-by-one in either bring-up step;
- the edges of the pixel window and the polarity half-periods;
- the frame wrap of the vertical strobe (k = 160 and 161).

Further patterns check the remaining behaviour:
- A gapped `pix_ce` checks that outputs hold while it is low and that the phase stays locked.
- A stray `start_i` mid-run must leave the phase untouched.
- A stop asserted together with a start must win.
- A restart must replay exactly the same sequence from k = 0.

// File: rtl/tft_tgen_pkg.sv
package tft_tgen_pkg;
  // channel slots inside the strobe bank
  localparam int unsigned CH_POL   = 0;
  localparam int unsigned CH_LATCH = 1;
  localparam int unsigned CH_HST   = 2;
  localparam int unsigned CH_VST   = 3;
  localparam int unsigned CH_PWIN  = 4;
  localparam int unsigned NUM_CH   = 5;

  typedef struct packed {
    logic line_latch;
    logic hstart;
    logic vstart;
    logic pix_win_n;
    logic polarity;
  } strobe_vec_t;

  function automatic int unsigned cnt_bits(input int unsigned limit);
    return $clog2(limit + 1);
  endfunction
endpackage

// File: rtl/tft_wrap_ctr.sv
module tft_wrap_ctr #(
  parameter int unsigned PERIOD = 303,
  parameter int unsigned CW     = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          en,
  input  logic          ce,
  output logic [CW-1:0] cnt_o
);
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt_q <= '0;
    else if (clr)       cnt_q <= '0;
    else if (en && ce)  cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  AST_CNT_IN_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST); // R2
  AST_HOLD_NO_CE: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce && !clr) |=> $stable(cnt_q)); // R7
  AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0)); // R9
endmodule

// File: rtl/tft_strobe_bank.sv
module tft_strobe_bank
  import tft_tgen_pkg::*;
#(
  parameter int unsigned LINE_CLKS  = 303,
  parameter int unsigned FRAME_CLKS = 99687,
  parameter int unsigned PIXWIN_W   = 248,
  parameter int unsigned CW         = 17
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr,
  input  logic                ce,
  input  logic [NUM_CH-1:0]   ch_en,
  output logic [NUM_CH-1:0]   strobe_o,
  output logic [CW-1:0]       pol_cnt_o,
  output logic [CW-1:0]       latch_cnt_o
);
  // per-slot period, high-time and polarity, indexed by slot number
  localparam int unsigned CH_PERIOD [NUM_CH] =
    '{2*LINE_CLKS, LINE_CLKS, LINE_CLKS, FRAME_CLKS, LINE_CLKS};
  localparam int unsigned CH_WIDTH  [NUM_CH] =
    '{LINE_CLKS, 1, 1, 2*LINE_CLKS, PIXWIN_W};
  localparam bit          CH_LOW    [NUM_CH] =
    '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1};

  logic [CW-1:0] cnt [NUM_CH];

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    localparam logic [CW-1:0] WID = CW'(CH_WIDTH[i]);
    logic active;

    tft_wrap_ctr #(.PERIOD(CH_PERIOD[i]), .CW(CW)) u_ctr (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clr),
      .en    (ch_en[i]),
      .ce    (ce),
      .cnt_o (cnt[i])
    );

    assign active = ch_en[i] && (cnt[i] < WID);

    if (CH_LOW[i]) begin : g_low
      assign strobe_o[i] = ~active;
    end else begin : g_high
      assign strobe_o[i] = active;
    end
  end

  assign pol_cnt_o   = cnt[CH_POL];
  assign latch_cnt_o = cnt[CH_LATCH];
endmodule

// File: rtl/tft_bringup_seq.sv
module tft_bringup_seq #(
  parameter int unsigned CW       = 17,
  parameter int unsigned REV_GATE = 11,
  parameter int unsigned LP_GATE  = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          stop_i,
  input  logic          ce,
  input  logic [CW-1:0] pol_cnt,
  input  logic [CW-1:0] latch_cnt,
  output logic          pol_en,
  output logic          latch_en,
  output logic          grp_en
);
  localparam logic [CW-1:0] POL_TH   = CW'(REV_GATE);
  localparam logic [CW-1:0] LATCH_TH = CW'(LP_GATE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pol_en   <= 1'b0;
      latch_en <= 1'b0;
      grp_en   <= 1'b0;
    end else if (stop_i) begin
      pol_en   <= 1'b0;
      latch_en <= 1'b0;
      grp_en   <= 1'b0;
    end else begin
      if (start_i && !pol_en)
        pol_en <= 1'b1;
      if (pol_en && !latch_en && ce && (pol_cnt > POL_TH))
        latch_en <= 1'b1;
      if (latch_en && !grp_en && ce && (latch_cnt >= LATCH_TH))
        grp_en <= 1'b1;
    end
  end

  AST_LATCH_AFTER_POL: assert property (@(posedge clk) disable iff (!rst_n)
    latch_en |-> pol_en); // R3
  AST_GRP_AFTER_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    grp_en |-> latch_en); // R4
  AST_STOP_DROPS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    stop_i |=> (!pol_en && !latch_en && !grp_en)); // R9
  AST_START_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !stop_i) |=> pol_en); // R10
endmodule

// File: rtl/tft_timing_gen.sv
module tft_timing_gen
  import tft_tgen_pkg::*;
#(
  parameter int unsigned LINE_CLKS   = 303,
  parameter int unsigned ACT_PIX     = 240,
  parameter int unsigned START_LN    = 8,
  parameter int unsigned ACT_LINES   = 320,
  parameter int unsigned BLANK_LINES = 9,
  parameter int unsigned REV_GATE    = 11,
  parameter int unsigned LP_GATE     = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pix_ce,
  input  logic start_i,
  input  logic stop_i,
  output logic running_o,
  output logic line_latch_o,
  output logic hstart_o,
  output logic vstart_o,
  output logic pix_win_n_o,
  output logic polarity_o
);
  localparam int unsigned FRAME_LINES = ACT_LINES + BLANK_LINES;
  localparam int unsigned FRAME_CLKS  = LINE_CLKS * FRAME_LINES;
  localparam int unsigned PIXWIN_W    = ACT_PIX + START_LN;
  localparam int unsigned CW          = cnt_bits(FRAME_CLKS);

  logic              pol_en, latch_en, grp_en;
  logic [CW-1:0]     pol_cnt, latch_cnt;
  logic [NUM_CH-1:0] ch_en, ch_out;
  strobe_vec_t       strb;

  tft_bringup_seq #(.CW(CW), .REV_GATE(REV_GATE), .LP_GATE(LP_GATE)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .stop_i    (stop_i),
    .ce        (pix_ce),
    .pol_cnt   (pol_cnt),
    .latch_cnt (latch_cnt),
    .pol_en    (pol_en),
    .latch_en  (latch_en),
    .grp_en    (grp_en)
  );

  assign ch_en[CH_POL]   = pol_en;
  assign ch_en[CH_LATCH] = latch_en;
  assign ch_en[CH_HST]   = grp_en;
  assign ch_en[CH_VST]   = grp_en;
  assign ch_en[CH_PWIN]  = grp_en;

  tft_strobe_bank #(
    .LINE_CLKS  (LINE_CLKS),
    .FRAME_CLKS (FRAME_CLKS),
    .PIXWIN_W   (PIXWIN_W),
    .CW         (CW)
  ) u_bank (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr         (stop_i),
    .ce          (pix_ce),
    .ch_en       (ch_en),
    .strobe_o    (ch_out),
    .pol_cnt_o   (pol_cnt),
    .latch_cnt_o (latch_cnt)
  );

  assign strb.line_latch = ch_out[CH_LATCH];
  assign strb.hstart     = ch_out[CH_HST];
  assign strb.vstart     = ch_out[CH_VST];
  assign strb.pix_win_n  = ch_out[CH_PWIN];
  assign strb.polarity   = ch_out[CH_POL];

  assign running_o    = pol_en;
  assign line_latch_o = strb.line_latch;
  assign hstart_o     = strb.hstart;
  assign vstart_o     = strb.vstart;
  assign pix_win_n_o  = strb.pix_win_n;
  assign polarity_o   = strb.polarity;

  AST_LATCH_ONE_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (line_latch_o && pix_ce) |=> !line_latch_o); // R3
  AST_HSTART_ONE_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (hstart_o && pix_ce) |=> !hstart_o); // R4
  AST_IDLE_LEVELS: assert property (@(posedge clk) disable iff (!rst_n)
    !running_o |-> (!line_latch_o && !hstart_o && !vstart_o && pix_win_n_o && !polarity_o)); // R1
  AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_i |=> (!running_o && pix_win_n_o && !vstart_o)); // R9
endmodule

// File: tb/tft_timing_gen_test.sv
`timescale 1ns/1ps
module tft_timing_gen_test;
  localparam int L     = 24;
  localparam int APIX  = 12;
  localparam int STLN  = 2;
  localparam int ALN   = 4;
  localparam int BLN   = 2;
  localparam int RG    = 11;
  localparam int LG    = 3;
  localparam int FRM   = L * (ALN + BLN);
  localparam int PSW   = APIX + STLN;
  localparam int LOFF  = RG + 2;
  localparam int GOFF  = RG + LG + 3;

  localparam int NROW = 14;
  localparam int ROW_N [NROW] = '{0, 12, 13, 16, 17, 24, 31, 37, 41, 48, 64, 65, 160, 161};
  // {line_latch, hstart, vstart, pix_win_n, polarity}
  localparam logic [4:0] ROW_EXP [NROW] = '{5'b00011, 5'b00011, 5'b10011, 5'b00011,
    5'b01101, 5'b00100, 5'b00110, 5'b10110, 5'b01100, 5'b00101, 5'b00111, 5'b01001,
    5'b00011, 5'b01101};
  localparam string ROW_REQ [NROW] = '{"R2", "R3", "R3", "R4", "R4", "R2", "R6", "R3",
    "R4", "R2", "R5", "R5", "R5", "R5"};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pix_ce = 1'b0;
  logic start_i = 1'b0;
  logic stop_i = 1'b0;
  logic running_o, line_latch_o, hstart_o, vstart_o, pix_win_n_o, polarity_o;

  int checks = 0;
  int fails = 0;
  int n = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  tft_timing_gen #(
    .LINE_CLKS(L), .ACT_PIX(APIX), .START_LN(STLN), .ACT_LINES(ALN),
    .BLANK_LINES(BLN), .REV_GATE(RG), .LP_GATE(LG)
  ) uut (
    .clk(clk), .rst_n(rst_n), .pix_ce(pix_ce), .start_i(start_i), .stop_i(stop_i),
    .running_o(running_o), .line_latch_o(line_latch_o), .hstart_o(hstart_o),
    .vstart_o(vstart_o), .pix_win_n_o(pix_win_n_o), .polarity_o(polarity_o)
  );

  function automatic logic [4:0] outs();
    return {line_latch_o, hstart_o, vstart_o, pix_win_n_o, polarity_o};
  endfunction

  function automatic logic [4:0] model(input int k);
    logic lp, sp, sps, ps, pol;
    int g;
    pol = (k % (2 * L)) < L;
    lp  = (k >= LOFF) && (((k - LOFF) % L) == 0);
    if (k >= GOFF) begin
      g   = k - GOFF;
      sp  = (g % L) == 0;
      sps = (g % FRM) < 2 * L;
      ps  = !((g % L) < PSW);
    end else begin
      sp = 1'b0; sps = 1'b0; ps = 1'b1;
    end
    return {lp, sp, sps, ps, pol};
  endfunction

  task automatic chk5(input string req, input logic [4:0] got, input logic [4:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s k=%0d: got %b expected %b", req, n, got, exp);
    end
  endtask

  task automatic chk1(input string req, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s running: got %b expected %b", req, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic adv();
    pix_ce = 1'b1;
    step();
    n++;
  endtask

  task automatic sweep(input int count, input string req);
    for (int i = 0; i < count; i++) begin
      adv();
      chk5(req, outs(), model(n));
    end
  endtask

  task automatic kick();
    start_i = 1'b1;
    pix_ce  = 1'b1;
    step();
    start_i = 1'b0;
    n = 0;
  endtask

  initial begin
    logic [4:0] held;
    repeat (3) step();
    rst_n = 1'b1;
    step();
    // R1: idle levels after reset
    chk5("R1", outs(), 5'b00010);
    chk1("R1", running_o, 1'b0);
    pix_ce = 1'b1;
    repeat (4) step();
    chk5("R1", outs(), 5'b00010);

    // table walk from a fresh start
    kick();
    chk1("R10", running_o, 1'b1);
    for (int r = 0; r < NROW; r++) begin
      while (n < ROW_N[r]) adv();
      chk5(ROW_REQ[r], outs(), ROW_ENTRY(r));
    end
    sweep(60, "R6");

    // R7: pix_ce held low
    held = outs();
    pix_ce = 1'b0;
    for (int i = 0; i < 6; i++) begin
      step();
      chk5("R7", outs(), held);
    end
    sweep(40, "R7");
    for (int i = 0; i < 10; i++) begin
      pix_ce = i[0];
      step();
      if (i[0]) n++;
      chk5("R7", outs(), model(n));
    end

    // R8: start while running is ignored
    start_i = 1'b1;
    adv();
    start_i = 1'b0;
    chk5("R8", outs(), model(n));
    sweep(60, "R8");

    // R9: stop wins over start, then idle, then replay
    stop_i = 1'b1;
    start_i = 1'b1;
    step();
    stop_i = 1'b0;
    start_i = 1'b0;
    chk5("R9", outs(), 5'b00010);
    chk1("R9", running_o, 1'b0);
    repeat (5) step();
    chk5("R9", outs(), 5'b00010);
    kick();
    chk5("R9", outs(), model(0));
    chk1("R10", running_o, 1'b1);
    sweep(170, "R9");

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  function automatic logic [4:0] ROW_ENTRY(input int r);
    return ROW_EXP[r];
  endfunction

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule